// File: doc/BRIEF.md
# Supply-Fault Reset Sequencer

This block converts a digital supply-fault indication, produced by an external over/undervoltage comparator, into an active-low system reset. A fault must persist for a debounce interval before it has any effect. Once accepted, it drives the reset low and starts a hold-off delay. Any further fault seen during the hold-off restarts the delay from the beginning, so a supply that keeps glitching keeps the system in reset for longer than one nominal delay. Both intervals are counted on a free-running clock and are set by parameters. The defaults assume a 100 kHz tick: about 200 µs of debounce and a 50 ms hold-off.

The fault input is asynchronous and passes through a two-stage synchronizer before the control logic sees it. While reset is asserted, the relay drive output is held off and the alarm output is held on, whatever the relay request says. The same reset output also clears the neighbouring trigger-window supervisor. Power-on reset leaves the block with reset asserted and the hold-off already running, so the system is released only after one full delay with a clean supply.

Top module: `vrst_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `reset_n_o` is 0, `relay_drv_o` is 0 and `alarm_o` is 1. After `rst_n` is released, with `fault_i` held at 0, `reset_n_o` rises on the DLY_CYCLES-th rising clock edge after the release.
- R2: A `fault_i` pulse that is high for DEB_CYCLES clock edges or fewer, arriving while `reset_n_o` is 1, leaves `reset_n_o` at 1.
- R3: When `fault_i` is high for at least DEB_CYCLES+1 consecutive rising edges, starting from the idle state, `reset_n_o` falls on the (DEB_CYCLES+3)-th rising edge after `fault_i` was first driven high. Two of those edges are spent in the synchronizer.
- R4: While `reset_n_o` is 0, a `fault_i` pulse of any width restarts the full hold-off, even a pulse one cycle wide. The release the earlier fault would have caused is then suppressed.
- R5: `reset_n_o` rises on the (DLY_CYCLES+2)-th rising edge after the edge at which `fault_i` last went low, provided no fault occurs in between. It never rises while the synchronized fault is high.
- R6: `relay_drv_o` equals `relay_req_i` while `reset_n_o` is 1 and is 0 while `reset_n_o` is 0. `alarm_o` is always the inverse of `reset_n_o`.
- R7: If the synchronized fault reaches the control logic on the same edge at which the hold-off expires, restart wins and reset stays low. If the fault arrives one edge later, the release happens on time, and the new fault, being only one cycle long, starts an ordinary debounce that it fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fault_i | input | 1 | Asynchronous supply-fault indication, active high |
| relay_req_i | input | 1 | Relay drive request from the system |
| reset_n_o | output | 1 | Active-low system reset, registered |
| relay_drv_o | output | 1 | Relay drive, forced off during reset |
| alarm_o | output | 1 | Fault alarm, on during reset |

## Verification
The hold-off expiry and the restart by a new fault can fall on the same clock edge. The bench predicts the release edge of a running delay. It then injects a one-cycle fault timed so that its synchronized copy reaches the control logic either exactly at that edge or one edge later. In the first case, the scoreboard expects no release at the predicted edge and a single release one full delay later. In the second case, it expects the release on time and no further reset edge, because the late fault then fails its debounce.

// File: rtl/vrst_pkg.sv
package vrst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_DEBOUNCE = 2'd1,
    ST_DELAY    = 2'd2,
    ST_REDELAY  = 2'd3
  } vrst_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit <= 1) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/vrst_sync.sv
module vrst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = din;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/vrst_timer.sv
module vrst_timer #(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);

  localparam int unsigned W = vrst_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (en && !done)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LAST);

  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/vrst_reset_ctrl.sv
module vrst_reset_ctrl
  import vrst_pkg::*;
#(
  parameter int unsigned DEB_CYCLES  = 20,
  parameter int unsigned DLY_CYCLES  = 5000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic relay_req_i,
  output logic reset_n_o,
  output logic relay_drv_o,
  output logic alarm_o
);

  vrst_state_e state_q, state_d;
  logic fault_s;
  logic fault_q;
  logic deb_clr, deb_en, deb_done;
  logic dly_clr, dly_en, dly_done;
  logic rst_q, rst_d;

  vrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (fault_i),
    .dout  (fault_s)
  );

  vrst_timer #(.LIMIT(DEB_CYCLES)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (deb_clr),
    .en    (deb_en),
    .done  (deb_done)
  );

  vrst_timer #(.LIMIT(DLY_CYCLES)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (dly_clr),
    .en    (dly_en),
    .done  (dly_done)
  );

  always_comb begin
    state_d = state_q;
    deb_clr = 1'b1;
    deb_en  = 1'b0;
    dly_clr = 1'b1;
    dly_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fault_s) state_d = ST_DEBOUNCE;
      end
      ST_DEBOUNCE: begin
        deb_clr = 1'b0;
        deb_en  = fault_s;
        if (!fault_s)      state_d = ST_IDLE;
        else if (deb_done) state_d = ST_DELAY;
      end
      ST_DELAY, ST_REDELAY: begin
        dly_clr = fault_s;
        dly_en  = 1'b1;
        if (fault_s && !fault_q)       state_d = ST_REDELAY;
        else if (dly_done && !fault_s) state_d = ST_IDLE;
      end
      default: state_d = ST_DELAY;
    endcase
  end

  always_comb rst_d = (state_d == ST_IDLE) || (state_d == ST_DEBOUNCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DELAY;
      fault_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_s;
      rst_q   <= rst_d;
    end
  end

  assign reset_n_o   = rst_q;
  assign relay_drv_o = rst_q & relay_req_i;
  assign alarm_o     = ~rst_q;

  // R3: reset only falls after the debounce timer completed with the fault present
  p_fall_after_debounce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> $past(deb_done && fault_s));

  // R5: release needs an expired hold-off and a quiet input
  p_rise_after_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(dly_done && !fault_s));

  // R5: no release while the synchronized fault is present
  p_hold_in_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_s && !rst_q) |=> !rst_q);

  generate
    if (DLY_CYCLES > 1) begin : g_restart_chk
      // R4: a fault during reset restarts the hold-off timer
      p_retrigger_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_s && !rst_q && (state_q != ST_DEBOUNCE)) |=> !dly_done);
    end
  endgenerate

endmodule

// File: tb/tb_vrst_reset_ctrl.sv
module tb_vrst_reset_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEB = 8;
  localparam int DLY = 40;

  typedef struct {
    bit    val;
    int    cyc;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic fault_i;
  logic relay_req_i;
  logic reset_n_o, relay_drv_o, alarm_o;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit prev_rn = 1'b0;
  exp_t q[$];

  vrst_reset_ctrl #(.DEB_CYCLES(DEB), .DLY_CYCLES(DLY), .SYNC_STAGES(2)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_i     (fault_i),
    .relay_req_i (relay_req_i),
    .reset_n_o   (reset_n_o),
    .relay_drv_o (relay_drv_o),
    .alarm_o     (alarm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic expect_edge(input bit v, input int c, input string tag);
    exp_t e;
    e.val = v; e.cyc = c; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic pulse(input int w);
    fault_i = 1'b1;
    step(w);
    fault_i = 1'b0;
  endtask

  task automatic finish_run;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(1'b0, e.tag, -1, e.cyc);
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // Monitor: every change of reset_n_o must match the next expected item
  always @(negedge clk) begin
    if (reset_n_o !== prev_rn) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk((reset_n_o == e.val) && (cyc == e.cyc), e.tag, cyc, e.cyc);
      end
      prev_rn = reset_n_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int n, x, m;
    rst_n = 1'b0;
    fault_i = 1'b0;
    relay_req_i = 1'b1;
    step(3);
    // R1 reset state
    chk(reset_n_o == 1'b0, "R1", reset_n_o, 0);
    chk(relay_drv_o == 1'b0, "R1", relay_drv_o, 0);
    chk(alarm_o == 1'b1, "R1", alarm_o, 1);
    expect_edge(1'b1, cyc + DLY, "R1");
    rst_n = 1'b1;
    step(DLY + 5);

    // R6 relay follows request while released
    chk(relay_drv_o == 1'b1, "R6", relay_drv_o, 1);
    chk(alarm_o == 1'b0, "R6", alarm_o, 0);
    relay_req_i = 1'b0;
    step(1);
    chk(relay_drv_o == 1'b0, "R6", relay_drv_o, 0);
    relay_req_i = 1'b1;
    step(2);

    // R2 pulse of exactly DEB cycles is ignored
    pulse(DEB);
    step(30);
    chk(reset_n_o == 1'b1, "R2", reset_n_o, 1);
    pulse(2);
    step(20);
    chk(reset_n_o == 1'b1, "R2", reset_n_o, 1);

    // R3 minimal accepted width DEB+1, R5 release timing
    n = cyc;
    expect_edge(1'b0, n + DEB + 3, "R3");
    expect_edge(1'b1, n + DEB + 1 + DLY + 2, "R5");
    pulse(DEB + 1);
    step_to(n + DEB + 5);
    chk(relay_drv_o == 1'b0, "R6", relay_drv_o, 0);
    chk(alarm_o == 1'b1, "R6", alarm_o, 1);
    step_to(n + DEB + 1 + DLY + 8);

    // R5 long fault holds reset beyond one delay
    n = cyc;
    expect_edge(1'b0, n + DEB + 3, "R3");
    expect_edge(1'b1, n + 60 + DLY + 2, "R5");
    pulse(60);
    step_to(n + 60 + DLY);
    chk(reset_n_o == 1'b0, "R5", reset_n_o, 0);
    step_to(n + 60 + DLY + 8);

    // R4 single-cycle glitch during delay restarts it
    n = cyc;
    m = n + 12 + 20;
    expect_edge(1'b0, n + DEB + 3, "R3");
    expect_edge(1'b1, m + 1 + DLY + 2, "R4");
    pulse(12);
    step_to(m);
    pulse(1);
    step_to(n + 12 + DLY + 3);
    chk(reset_n_o == 1'b0, "R4", reset_n_o, 0);
    step_to(m + DLY + 10);

    // R7 fault reaches control logic on the expiry edge: restart wins
    n = cyc;
    x = n + DEB + 1 + DLY + 2;
    expect_edge(1'b0, n + DEB + 3, "R3");
    expect_edge(1'b1, x + DLY, "R7");
    pulse(DEB + 1);
    step_to(x - 3);
    pulse(1);
    step_to(x + 1);
    chk(reset_n_o == 1'b0, "R7", reset_n_o, 0);
    step_to(x + DLY + 6);

    // R7 fault one edge late: release on time, glitch then ignored
    n = cyc;
    x = n + DEB + 1 + DLY + 2;
    expect_edge(1'b0, n + DEB + 3, "R3");
    expect_edge(1'b1, x, "R7");
    pulse(DEB + 1);
    step_to(x - 2);
    pulse(1);
    step_to(x + 30);
    chk(reset_n_o == 1'b1, "R7", reset_n_o, 1);

    finish_run();
  end

endmodule